// File: doc/BRIEF.md
# SDRAM Mode Register Programming Controller

This block lives inside a memory controller and writes the base mode register of a DDR2-class SDRAM. A host presents one request carrying the wanted read latency, burst size, burst ordering, the write-recovery time and clock period in picoseconds, a DLL-reset flag and the power-down exit choice. The block works out the write-recovery cycle count by a rounded-up division, packs every field into the 13-bit address word and checks each field against the legal codes.

A legal request produces exactly one mode-register command on the command bus. The command goes out only while the host reports that all banks are precharged and that the clock enable is high. After it, the block holds off for a set number of command-to-command cycles. An illegal request produces a one-cycle error flag and no command. In every other cycle the bus carries a no-operation command.

Top module: `mrs_ctrl`

## Requirements
- R1: A command cycle drives csN, rasN, casN and weN all low with ba = 2'b00. It lasts exactly one clock.
- R2: In every cycle that is not a command cycle, csN is 0, rasN, casN and weN are 1, ba is 2'b00 and addr is all zeros. After reset, busy and errFlag are 0.
- R3: addr[2:0] is 3'b010 for a burst of 4 and 3'b011 for a burst of 8. Any other burst size is rejected.
- R4: addr[3] equals the burst-order input: 0 for sequential, 1 for interleaved.
- R5: addr[6:4] holds the read latency in binary. Only latencies 3, 4, 5 and 6 are accepted.
- R6: addr[7] is always 0. addr[8] equals the DLL-reset input.
- R7: The write-recovery count is ceil(tWrPs / tCkPs). addr[11:9] holds that count minus one. Only counts 3, 4 and 5 are accepted, and tCkPs = 0 is rejected.
- R8: addr[12] equals the slow-exit input: 0 for fast exit, 1 for slow exit.
- R9: A legal request waits, with busy high, until banksIdle and ckeHigh are both 1 in the same cycle. No command is issued before that.
- R10: busy rises in the cycle after reqValid is accepted. After the command cycle it stays high for exactly MRD_CYCLES further cycles, with no other command in that window, and then falls.
- R11: A rejected request raises errFlag for exactly one cycle and issues no command.
- R12: reqValid is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| casLat | input | 3 | Read latency in cycles |
| burstLen | input | 4 | Burst size in beats |
| burstIlv | input | 1 | 1 = interleaved order |
| dllReset | input | 1 | Request DLL reset |
| slowExit | input | 1 | 1 = slow power-down exit |
| tWrPs | input | 16 | Write-recovery time, ps |
| tCkPs | input | 16 | Clock period, ps |
| banksIdle | input | 1 | All banks precharged |
| ckeHigh | input | 1 | Clock enable is high |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Address bus |
| busy | output | 1 | Request in progress |
| errFlag | output | 1 | One-cycle reject pulse |

## Verification
The hardest case to reach is a request that arrives while the bus is not ready and has to be held back. A second request landing in that same window must be dropped. The stimulus lowers banksIdle before a legal request and waits well past the division. While the block waits, it pulses reqValid with different field values. It then restores banksIdle but drops ckeHigh, and finally raises ckeHigh. The scoreboard must see exactly one command, carrying the first request's word.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV,
    ST_CHECK,
    ST_WAIT,
    ST_ISSUE,
    ST_HOLD,
    ST_ERR
  } mrs_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } mrs_strobe_t;

  localparam logic [2:0] BL4_CODE = 3'b010;
  localparam logic [2:0] BL8_CODE = 3'b011;

endpackage

// File: rtl/mrs_datapath.sv
module mrs_datapath
  import mrs_pkg::*;
#(
  parameter int PS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mrs_strobe_t       stb,
  input  logic [2:0]        casLat,
  input  logic [3:0]        burstLen,
  input  logic              burstIlv,
  input  logic              dllReset,
  input  logic              slowExit,
  input  logic [PS_W-1:0]   tWrPs,
  input  logic [PS_W-1:0]   tCkPs,
  output logic              divDone,
  output logic              fieldsOk,
  output logic [12:0]       addrWord
);

  localparam int NW  = PS_W + 1;            // dividend width (tWr + tCk - 1)
  localparam int CW  = $clog2(NW + 1);

  logic [2:0]    clR;
  logic [3:0]    blR;
  logic          btR, dllR, slowR, tckZeroR;
  logic [NW:0]   remR;
  logic [NW:0]   divR;
  logic [NW-1:0] quoR;
  logic [CW-1:0] stepCnt;

  logic [NW:0]   remShift;
  logic          remGe;

  always_comb begin
    remShift = {remR[NW-1:0], quoR[NW-1]};
    remGe    = (remShift >= divR);
  end

  assign divDone = (stepCnt == CW'(NW));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clR      <= '0;
      blR      <= '0;
      btR      <= 1'b0;
      dllR     <= 1'b0;
      slowR    <= 1'b0;
      tckZeroR <= 1'b0;
      remR     <= '0;
      divR     <= '0;
      quoR     <= '0;
      stepCnt  <= '0;
    end else if (stb.load) begin
      clR      <= casLat;
      blR      <= burstLen;
      btR      <= burstIlv;
      dllR     <= dllReset;
      slowR    <= slowExit;
      tckZeroR <= (tCkPs == '0);
      remR     <= '0;
      divR     <= {2'b00, tCkPs};
      quoR     <= {1'b0, tWrPs} + {1'b0, tCkPs} - NW'(1);
      stepCnt  <= '0;
    end else if (stb.step && !divDone) begin
      if (remGe) begin
        remR <= remShift - divR;
        quoR <= {quoR[NW-2:0], 1'b1};
      end else begin
        remR <= remShift;
        quoR <= {quoR[NW-2:0], 1'b0};
      end
      stepCnt <= stepCnt + CW'(1);
    end
  end

  logic       clOk, blOk, wrOk;
  logic [2:0] blCode, wrCode;

  always_comb begin
    clOk   = (clR >= 3'd3) && (clR <= 3'd6);
    blOk   = (blR == 4'd4) || (blR == 4'd8);
    wrOk   = !tckZeroR && (quoR >= NW'(3)) && (quoR <= NW'(5));
    blCode = (blR == 4'd8) ? BL8_CODE : BL4_CODE;
    wrCode = quoR[2:0] - 3'd1;
  end

  assign fieldsOk = clOk && blOk && wrOk;
  assign addrWord = {slowR, wrCode, dllR, 1'b0, clR, btR, blCode};

endmodule

// File: rtl/mrs_ctrl_fsm.sv
module mrs_ctrl_fsm
  import mrs_pkg::*;
#(
  parameter int MRD_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        divDone,
  input  logic        fieldsOk,
  input  logic        banksIdle,
  input  logic        ckeHigh,
  output mrs_strobe_t stb,
  output logic        issueCmd,
  output logic        busy,
  output logic        errFlag
);

  localparam int HW = $clog2(MRD_CYCLES + 1);

  mrs_state_e    state, stateNext;
  logic [HW-1:0] holdCnt;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (reqValid) stateNext = ST_DIV;
      ST_DIV:   if (divDone) stateNext = ST_CHECK;
      ST_CHECK: stateNext = fieldsOk ? ST_WAIT : ST_ERR;
      ST_WAIT:  if (banksIdle && ckeHigh) stateNext = ST_ISSUE;
      ST_ISSUE: stateNext = ST_HOLD;
      ST_HOLD:  if (holdCnt == '0) stateNext = ST_IDLE;
      ST_ERR:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_ISSUE) holdCnt <= HW'(MRD_CYCLES - 1);
      else if (state == ST_HOLD && holdCnt != '0) holdCnt <= holdCnt - HW'(1);
    end
  end

  always_comb begin
    stb.load = (state == ST_IDLE) && reqValid;
    stb.step = (state == ST_DIV);
  end

  assign issueCmd = (state == ST_ISSUE);
  assign errFlag  = (state == ST_ERR);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
  import mrs_pkg::*;
#(
  parameter int PS_W       = 16,
  parameter int MRD_CYCLES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [2:0]      casLat,
  input  logic [3:0]      burstLen,
  input  logic            burstIlv,
  input  logic            dllReset,
  input  logic            slowExit,
  input  logic [PS_W-1:0] tWrPs,
  input  logic [PS_W-1:0] tCkPs,
  input  logic            banksIdle,
  input  logic            ckeHigh,
  output logic            csN,
  output logic            rasN,
  output logic            casN,
  output logic            weN,
  output logic [1:0]      ba,
  output logic [12:0]     addr,
  output logic            busy,
  output logic            errFlag
);

  mrs_strobe_t stb;
  logic        divDone, fieldsOk, issueCmd;
  logic [12:0] addrWord;

  mrs_datapath #(.PS_W(PS_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .casLat(casLat), .burstLen(burstLen), .burstIlv(burstIlv),
    .dllReset(dllReset), .slowExit(slowExit),
    .tWrPs(tWrPs), .tCkPs(tCkPs),
    .divDone(divDone), .fieldsOk(fieldsOk), .addrWord(addrWord)
  );

  mrs_ctrl_fsm #(.MRD_CYCLES(MRD_CYCLES)) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .divDone(divDone), .fieldsOk(fieldsOk),
    .banksIdle(banksIdle), .ckeHigh(ckeHigh),
    .stb(stb), .issueCmd(issueCmd), .busy(busy), .errFlag(errFlag)
  );

  // NOP is CS low with RAS/CAS/WE high; the command pulls all three low
  assign csN  = 1'b0;
  assign rasN = !issueCmd;
  assign casN = !issueCmd;
  assign weN  = !issueCmd;
  assign ba   = 2'b00;
  assign addr = issueCmd ? addrWord : 13'd0;

endmodule

// File: rtl/mrs_ctrl_chk.sv
module mrs_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        rasN,
  input logic        casN,
  input logic        weN,
  input logic [1:0]  ba,
  input logic [12:0] addr,
  input logic        busy,
  input logic        errFlag,
  input logic        banksIdle,
  input logic        ckeHigh
);

  logic cmdNow;
  assign cmdNow = !csN && !rasN && !casN && !weN;

  a_r1_bank_zero: assert property (@(posedge clk) disable iff (!rstN)
    cmdNow |-> (ba == 2'b00));
  a_r1_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    cmdNow |=> !cmdNow);
  a_r2_nop_shape: assert property (@(posedge clk) disable iff (!rstN)
    !cmdNow |-> (!csN && rasN && casN && weN && addr == 13'd0));
  a_r3_bl_code: assert property (@(posedge clk) disable iff (!rstN)
    cmdNow |-> (addr[2:0] == 3'b010 || addr[2:0] == 3'b011));
  a_r5_cl_code: assert property (@(posedge clk) disable iff (!rstN)
    cmdNow |-> (addr[6:4] >= 3'd3 && addr[6:4] <= 3'd6));
  a_r6_test_low: assert property (@(posedge clk) disable iff (!rstN)
    cmdNow |-> !addr[7]);
  a_r7_wr_code: assert property (@(posedge clk) disable iff (!rstN)
    cmdNow |-> (addr[11:9] >= 3'd2 && addr[11:9] <= 3'd4));
  a_r9_gated: assert property (@(posedge clk) disable iff (!rstN)
    cmdNow |-> (banksIdle && ckeHigh));
  a_r10_busy_after: assert property (@(posedge clk) disable iff (!rstN)
    cmdNow |=> busy);
  a_r10_busy_during: assert property (@(posedge clk) disable iff (!rstN)
    cmdNow |-> busy);
  a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> !errFlag);
  a_r11_err_no_cmd: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !cmdNow);

endmodule

bind mrs_ctrl mrs_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
  .ba(ba), .addr(addr), .busy(busy), .errFlag(errFlag),
  .banksIdle(banksIdle), .ckeHigh(ckeHigh)
);

// File: tb/sim_mrs_ctrl.sv
module sim_mrs_ctrl;

  localparam int PERIOD = 10;
  localparam int MRD    = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  casLat = '0;
  logic [3:0]  burstLen = '0;
  logic        burstIlv = 1'b0, dllReset = 1'b0, slowExit = 1'b0;
  logic [15:0] tWrPs = '0, tCkPs = '0;
  logic        banksIdle = 1'b1, ckeHigh = 1'b1;
  logic        csN, rasN, casN, weN, busy, errFlag;
  logic [1:0]  ba;
  logic [12:0] addr;

  int errors = 0;
  int checks = 0;
  int cmdCount = 0;
  int errCount = 0;
  bit done = 0;

  // bit 13 = expected reject, bits 12:0 = expected address word
  logic [13:0] expQ[$];

  mrs_ctrl #(.PS_W(16), .MRD_CYCLES(MRD)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .casLat(casLat),
    .burstLen(burstLen), .burstIlv(burstIlv), .dllReset(dllReset),
    .slowExit(slowExit), .tWrPs(tWrPs), .tCkPs(tCkPs),
    .banksIdle(banksIdle), .ckeHigh(ckeHigh), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .addr(addr), .busy(busy),
    .errFlag(errFlag)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [13:0] model(input int cl, input int bl, input bit bt,
                                         input int twr, input int tck,
                                         input bit dll, input bit slow);
    int wr;
    bit ok;
    logic [2:0] blc;
    wr  = (tck == 0) ? 0 : (twr + tck - 1) / tck;
    ok  = (cl >= 3 && cl <= 6) && (bl == 4 || bl == 8) && (tck != 0) && (wr >= 3 && wr <= 5);
    blc = (bl == 8) ? 3'b011 : 3'b010;
    if (!ok) return {1'b1, 13'd0};
    return {1'b0, slow, 3'(wr - 1), dll, 1'b0, 3'(cl), bt, blc};
  endfunction

  task automatic sendReq(input int cl, input int bl, input bit bt, input int twr,
                         input int tck, input bit dll, input bit slow, input bit push);
    @(negedge clk);
    while (busy) @(negedge clk);
    casLat = 3'(cl); burstLen = 4'(bl); burstIlv = bt;
    tWrPs = 16'(twr); tCkPs = 16'(tck); dllReset = dll; slowExit = slow;
    reqValid = 1'b1;
    if (push) expQ.push_back(model(cl, bl, bt, twr, tck, dll, slow));
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while ((expQ.size() != 0 || busy) && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(n < 500, "R10 request did not finish", n, 0);
  endtask

  // monitor: sample a quarter period after each rising edge
  initial begin
    int holdLeft = 0;
    bit errPrev = 0;
    logic [13:0] e;
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (rstN) begin
        bit cmd;
        cmd = !csN && !rasN && !casN && !weN;
        if (holdLeft > 0) begin
          if (holdLeft > 1)
            check(busy && !cmd, "R10 busy/no-cmd after command", {busy, cmd}, 2);
          else
            check(!busy, "R10 busy fall after MRD window", busy, 0);
          holdLeft--;
        end
        if (errFlag) begin
          errCount++;
          check(!errPrev, "R11 errFlag longer than one cycle", 1, 0);
          check(!cmd, "R11 command with errFlag", cmd, 0);
          if (expQ.size() == 0) check(0, "R11 unexpected reject", 1, 0);
          else begin
            e = expQ.pop_front();
            check(e[13], "R11 reject for legal request", 1, e[13]);
          end
        end
        if (cmd) begin
          cmdCount++;
          check(ba == 2'b00 && busy, "R1 bank/busy at command", {ba, busy}, 1);
          if (expQ.size() == 0) check(0, "R12 R1 unexpected command", addr, 0);
          else begin
            e = expQ.pop_front();
            // covers R3 R4 R5 R6 R7 R8 field packing
            check(!e[13] && addr == e[12:0], "R3 R4 R5 R6 R7 R8 address word",
                  addr, e[12:0]);
          end
          holdLeft = MRD + 1;
        end else if (!(!csN && rasN && casN && weN && ba == 2'b00 && addr == 13'd0)) begin
          check(0, "R2 idle bus not NOP", {csN, rasN, casN, weN, addr}, 16'h7000);
        end
        errPrev = errFlag;
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(!csN && rasN && casN && weN && addr == 0 && !busy && !errFlag,
          "R2 reset state", {busy, errFlag, addr}, 0);

    // legal patterns (R3 R4 R5 R6 R7 R8)
    sendReq(3, 4, 0, 15000, 5000, 0, 0, 1); waitIdle();   // exact 3
    sendReq(6, 8, 1, 15000, 3750, 1, 1, 1); waitIdle();   // exact 4
    sendReq(5, 4, 1, 15000, 3300, 0, 1, 1); waitIdle();   // R7 round up to 5
    sendReq(4, 8, 0, 15000, 4000, 1, 0, 1); waitIdle();   // R7 3.75 -> 4

    // rejects (R11, R3 R5 R7)
    c0 = cmdCount;
    sendReq(7, 4, 0, 15000, 5000, 0, 0, 1); waitIdle();   // R5 latency 7
    sendReq(2, 8, 0, 15000, 5000, 0, 0, 1); waitIdle();   // R5 latency 2
    sendReq(4, 16, 0, 15000, 5000, 0, 0, 1); waitIdle();  // R3 burst 16
    sendReq(4, 2, 0, 15000, 5000, 0, 0, 1); waitIdle();   // R3 burst 2
    sendReq(4, 4, 0, 15000, 2500, 0, 0, 1); waitIdle();   // R7 wr 6
    sendReq(4, 4, 0, 15000, 7500, 0, 0, 1); waitIdle();   // R7 wr 2
    sendReq(4, 4, 0, 15000, 0, 0, 0, 1); waitIdle();      // R7 tck zero
    check(cmdCount == c0, "R11 command issued for reject", cmdCount - c0, 0);
    check(errCount == 7, "R11 reject count", errCount, 7);

    // gating (R9) with ignored request while busy (R12)
    c0 = cmdCount;
    banksIdle = 1'b0;
    sendReq(5, 8, 1, 15000, 3000, 1, 0, 1);
    repeat (40) @(negedge clk);
    check(cmdCount == c0 && busy, "R9 waited while banks busy", cmdCount - c0, 0);
    reqValid = 1'b1; casLat = 3'd3; burstLen = 4'd4; tCkPs = 16'd5000;
    @(negedge clk);
    reqValid = 1'b0;
    banksIdle = 1'b1; ckeHigh = 1'b0;
    repeat (10) @(negedge clk);
    check(cmdCount == c0 && busy, "R9 waited while CKE low", cmdCount - c0, 0);
    ckeHigh = 1'b1;
    waitIdle();
    repeat (5) @(negedge clk);
    check(cmdCount == c0 + 1, "R12 single command after busy request", cmdCount - c0, 1);
    check(expQ.size() == 0, "R12 scoreboard drained", expQ.size(), 0);

    finishRun();
  end

endmodule